// File: doc/BRIEF.md
# Biphase Mark Line Encoder

This block turns a stream of single data bits into a biphase-mark line signal. A bit cell is two half-cell steps long, and a step happens only on a clock edge where the half-cell enable strobe is high, so the strobe sets the line rate independently of the system clock. The line level always flips at a cell boundary. It flips again at mid-cell only when the bit is a one.

The data source sees a ready/valid pair. Ready is high only while the encoder waits at a cell boundary. A bit is taken on an enabled step where valid and ready are both high. That bit is held internally until the mid-cell step uses it, so the source may change its data right after the handshake. While valid stays low, the encoder waits at the boundary and the line does not move. The line output and the ready flag both come from registers.

Top module: `bmp_encoder`

## Requirements
- R1: While rst_ni is low, and right after it is released, line_o is 1 and ready_o is 1. This holds even when reset arrives in the middle of a cell.
- R2: ready_o is 1 exactly when the encoder is in the boundary phase. It falls after a bit is accepted and rises again after the mid-cell step.
- R3: An enabled step with ready_o=1 and valid_i=1 inverts line_o and drops ready_o. The value of bit_i is captured at that edge.
- R4: An enabled step with ready_o=0 inverts line_o when the captured bit is 1, then raises ready_o.
- R5: An enabled step with ready_o=0 keeps line_o unchanged when the captured bit is 0, then raises ready_o.
- R6: An enabled step with ready_o=1 and valid_i=0 changes neither line_o nor ready_o.
- R7: With step_en_i=0, line_o and ready_o keep their values in either phase, whatever valid_i and bit_i do.
- R8: Changes on bit_i after acceptance have no effect on the mid-cell transition.
- R9: valid_i has no effect while ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Half-cell step strobe |
| valid_i | input | 1 | Source offers a bit |
| bit_i | input | 1 | Data bit offered |
| ready_o | output | 1 | Encoder waits at a cell boundary |
| line_o | output | 1 | Biphase-mark line signal |

## Verification
Both line_o and ready_o are registered. Each one therefore reflects a step exactly one clock edge after the edge that carried the strobe. The bench drives its inputs on the falling edge and checks the outputs on the next falling edge, which lands half a period after the rising edge that updates them. For reset, the outputs are checked while rst_ni is still low, because the reset is asynchronous and acts at once.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  typedef enum logic {
    PH_MID  = 1'b0,
    PH_EDGE = 1'b1
  } phase_e;
endpackage

// File: rtl/bmp_phase_ctl.sv
module bmp_phase_ctl
  import bmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_en_i,
  input  logic valid_i,
  output logic edge_o,
  output logic accept_o,
  output logic mid_step_o
);
  phase_e phase_q, phase_d;

  assign edge_o     = (phase_q == PH_EDGE);
  assign accept_o   = step_en_i && edge_o && valid_i;
  assign mid_step_o = step_en_i && !edge_o;

  always_comb begin
    phase_d = phase_q;
    if (accept_o)   phase_d = PH_MID;
    if (mid_step_o) phase_d = PH_EDGE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_EDGE;
    else         phase_q <= phase_d;
  end

  AST_PHASE_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_step_o |=> edge_o); // R2
  AST_STALL_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !valid_i) |=> edge_o); // R6
endmodule

// File: rtl/bmp_bit_hold.sv
module bmp_bit_hold #(
  parameter logic HOLD_INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bit_q <= HOLD_INIT;
    else if (load_i) bit_q <= bit_i;
  end

  assign bit_o = bit_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bit_q)); // R8
endmodule

// File: rtl/bmp_line_drv.sv
module bmp_line_drv #(
  parameter logic LINE_INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic mid_step_i,
  input  logic held_bit_i,
  output logic line_o
);
  logic line_q;
  logic flip;

  // boundary always flips; mid-cell flips only for a one
  assign flip = accept_i || (mid_step_i && held_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   line_q <= LINE_INIT;
    else if (flip) line_q <= ~line_q;
  end

  assign line_o = line_q;
endmodule

// File: rtl/bmp_encoder.sv
module bmp_encoder #(
  parameter logic LINE_INIT = 1'b1,
  parameter logic HOLD_INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_en_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic ready_o,
  output logic line_o
);
  logic edge_w, accept_w, mid_step_w, held_w;

  bmp_phase_ctl u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_en_i  (step_en_i),
    .valid_i    (valid_i),
    .edge_o     (edge_w),
    .accept_o   (accept_w),
    .mid_step_o (mid_step_w)
  );

  bmp_bit_hold #(.HOLD_INIT(HOLD_INIT)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept_w),
    .bit_i  (bit_i),
    .bit_o  (held_w)
  );

  bmp_line_drv #(.LINE_INIT(LINE_INIT)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept_w),
    .mid_step_i (mid_step_w),
    .held_bit_i (held_w),
    .line_o     (line_o)
  );

  assign ready_o = edge_w;

  AST_EDGE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && ready_o && valid_i) |=> (line_o != $past(line_o)) && !ready_o); // R3
  AST_MID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !ready_o && held_w) |=> (line_o != $past(line_o)) && ready_o); // R4
  AST_MID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !ready_o && !held_w) |=> $stable(line_o) && ready_o); // R5
  AST_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(line_o) && $stable(ready_o)); // R7
  AST_STALL_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> $stable(line_o)); // R6
endmodule

// File: tb/sim_bmp_encoder.sv
module sim_bmp_encoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_en = 1'b0, valid = 1'b0, bit_in = 1'b0;
  logic ready, line;
  int checks = 0, errors = 0;

  always #10 clk = ~clk; // 50 MHz

  bmp_encoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en),
    .valid_i(valid), .bit_i(bit_in), .ready_o(ready), .line_o(line)
  );

  // {step, valid, bit, exp_line, exp_ready, req[3:0]}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {5'b11100, 4'd3}, // R3 accept 1
    {5'b10011, 4'd4}, // R4 mid one flips
    {5'b11000, 4'd3}, // R3 accept 0
    {5'b11101, 4'd5}, // R5 mid zero holds, R9 valid ignored, R8 bit_i ignored
    {5'b01101, 4'd7}, // R7 no step at boundary
    {5'b10101, 4'd6}, // R6 stall without valid
    {5'b11110, 4'd2}, // R2 accept, ready falls
    {5'b00010, 4'd7}, // R7 no step mid-cell
    {5'b10001, 4'd8}, // R8 bit_i dropped, held one still flips
    {5'b11010, 4'd3}, // R3 accept 0
    {5'b10111, 4'd8}, // R8 bit_i raised, held zero holds
    {5'b11100, 4'd3}, // R3
    {5'b11111, 4'd9}  // R9 valid high mid-cell, held one flips
  };

  task automatic chk(input logic exp_line, input logic exp_ready, input int req);
    checks++;
    if (line !== exp_line || ready !== exp_ready) begin
      errors++;
      $display("FAIL R%0d line=%b ready=%b expected line=%b ready=%b",
               req, line, ready, exp_line, exp_ready);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(1'b1, 1'b1, 1); // R1 in reset
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1'b1, 1'b1, 1); // R1 after release
    for (int i = 0; i < NV; i++) begin
      {step_en, valid, bit_in} = VEC[i][8:6];
      @(negedge clk);
      chk(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end
    // R1: reset in mid-cell
    step_en = 1'b1; valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    chk(1'b0, 1'b0, 3);
    step_en = 1'b0; valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(1'b1, 1'b1, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1'b1, 1'b1, 1);
    // R2: long stall stays ready, then a full zero cell
    step_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(1'b1, 1'b1, 6);
    valid = 1'b1; bit_in = 1'b0;
    @(negedge clk);
    chk(1'b0, 1'b0, 2);
    valid = 1'b0;
    @(negedge clk);
    chk(1'b0, 1'b1, 5);
    step_en = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule